// File: doc/BRIEF.md
# Serial-Loaded Latched Column Driver

This block drives the column lines of a multiplexed display. A one-bit serial stream is loaded into a chain of `N` storage stages. Each beat that is accepted moves every stage one place further along the chain. A bank of level-sensitive hold cells stands between the chain and the output pins. While `latch_open` is high the pins follow the chain, and a shift is visible in the same cycle. While it is low the pins keep the pattern that was in the chain when it fell. The chain can therefore be refilled with the next pattern while the current one stays on the display.

A blanking input forces every column pin low and does not disturb the held pattern. The last stage of the chain is presented on a cascade port, so several drivers can be chained into one longer register.

Serial data uses a valid/ready handshake. A beat moves the chain when `in_valid` and `in_ready` are both high. The driver adds no stall of its own: `in_ready` is `casc_ready` passed straight through, and `casc_valid` is `in_valid` passed straight through. When several drivers are chained, the whole chain therefore stalls, or shifts, as one unit. A driver used alone ties `casc_ready` high.

Top module: `col_shift_driver`

## Requirements
- R1: An active-low asynchronous reset clears the chain and the hold bank to zero. All column pins and `casc_bit` are low during reset and after it, until new data is loaded.
- R2: On each clock edge with an accepted beat, stage 0 (`col_out[0]`) takes `in_bit`, and stage k takes the old value of stage k-1. After `N` beats, the first bit loaded sits in stage `N-1`.
- R3: On a clock edge without an accepted beat, the chain keeps its contents.
- R4: While `latch_open` is high and `blank` is low, `col_out` equals the chain contents. A shift is visible in the cycle that follows its clock edge.
- R5: While `latch_open` is low, `col_out` holds the chain contents as they stood at the last clock edge where `latch_open` was high. Shifts in the meantime do not change the pins.
- R6: While `blank` is high, every column pin is low. When `blank` returns low, the pins show the unchanged held or transparent value.
- R7: `casc_bit` always equals stage `N-1`. `latch_open` and `blank` have no effect on it.
- R8: `in_ready` follows `casc_ready`, and `casc_valid` follows `in_valid`. No beat is taken while `casc_ready` is low.
- R9: Two drivers joined through their cascade ports (`casc_bit` to `in_bit`, `casc_valid` to `in_valid`, `in_ready` to `casc_ready`) behave as one chain of `2N` stages. The downstream driver holds stages `N` to `2N-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Serial beat present |
| in_ready | output | 1 | Serial beat accepted (equals `casc_ready`) |
| in_bit | input | 1 | Serial data bit |
| latch_open | input | 1 | High: hold bank is transparent. Low: hold bank keeps its value |
| blank | input | 1 | High: all column pins forced low |
| casc_valid | output | 1 | Cascade beat present (equals `in_valid`) |
| casc_ready | input | 1 | Downstream can accept a beat |
| casc_bit | output | 1 | Last chain stage, feeds the next driver |
| col_out | output | N | Gated column pins |

## Verification
The assertions assume that `latch_open` and `blank` change only between clock edges, away from the sampling edge. Under that assumption, a hold across two sampled cycles means the pins did not move. The bench drives every input on the falling edge, so both levels are steady at each rising edge. The bench also holds reset long enough that the past values seen by the assertions come from the cleared state. The stimulus keeps `N` at least 2, so the cascade check can refer to the next-to-last stage.

// File: rtl/col_shift_driver_pkg.sv
package col_shift_driver_pkg;

  // Gating controls seen by the output stage
  typedef struct packed {
    logic open;   // hold bank transparent
    logic blank;  // force all pins low
  } view_ctrl_t;

endpackage

// File: rtl/cd_shift_chain.sv
module cd_shift_chain #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] stages,
  output logic [N-1:0] stages_nxt
);

  // Next contents: stage 0 takes din, stage k takes stage k-1
  always_comb begin
    stages_nxt = stages;
    if (step) begin
      stages_nxt = {stages[N-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= stages_nxt;
  end

endmodule

// File: rtl/cd_hold_bank.sv
module cd_hold_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [N-1:0] tap,
  input  logic [N-1:0] fill,
  output logic [N-1:0] view
);

  logic [N-1:0] held;

  // One hold cell per column. Capture the post-edge chain value so the
  // held state equals the chain at the last edge where open was high.
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held[i] <= 1'b0;
      else if (open) held[i] <= fill[i];
    end
    assign view[i] = open ? tap[i] : held[i];
  end

endmodule

// File: rtl/cd_blank_gate.sv
module cd_blank_gate #(
  parameter int N = 32
) (
  input  col_shift_driver_pkg::view_ctrl_t ctrl,
  input  logic [N-1:0]                     view,
  output logic [N-1:0]                     pins
);

  for (genvar i = 0; i < N; i++) begin : g_and
    assign pins[i] = view[i] & ~ctrl.blank;
  end

endmodule

// File: rtl/col_shift_driver.sv
module col_shift_driver #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  input  logic         latch_open,
  input  logic         blank,
  output logic         casc_valid,
  input  logic         casc_ready,
  output logic         casc_bit,
  output logic [N-1:0] col_out
);

  import col_shift_driver_pkg::*;

  logic [N-1:0] stages;
  logic [N-1:0] stages_nxt;
  logic [N-1:0] view;
  logic         step;
  view_ctrl_t   ctrl;

  // Back-pressure passes straight through so a chain stalls as one unit
  assign in_ready   = casc_ready;
  assign casc_valid = in_valid;
  assign step       = in_valid & casc_ready;

  assign ctrl.open  = latch_open;
  assign ctrl.blank = blank;

  cd_shift_chain #(.N(N)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .din        (in_bit),
    .stages     (stages),
    .stages_nxt (stages_nxt)
  );

  cd_hold_bank #(.N(N)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .open  (ctrl.open),
    .tap   (stages),
    .fill  (stages_nxt),
    .view  (view)
  );

  cd_blank_gate #(.N(N)) u_gate (
    .ctrl (ctrl),
    .view (view),
    .pins (col_out)
  );

  assign casc_bit = stages[N-1];

endmodule

// File: rtl/col_shift_driver_chk.sv
module col_shift_driver_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_bit,
  input logic         latch_open,
  input logic         blank,
  input logic         casc_bit,
  input logic [N-1:0] col_out,
  input logic [N-1:0] stages
);

  // R2: accepted beat enters stage 0
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> stages[0] == $past(in_bit));

  // R3: no beat, no movement
  a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(stages));

  // R4: transparent view
  a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_open && !blank) |-> col_out == stages);

  // R5: closed and unblanked over two sampled cycles keeps the pins
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_open && !blank && $past(!latch_open && !blank)) |-> $stable(col_out));

  // R6: blanking clears every pin
  a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> col_out == '0);

  // R7: cascade bit advances from the next-to-last stage
  a_r7_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> casc_bit == $past(stages[N-2]));

endmodule

bind col_shift_driver col_shift_driver_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bit     (in_bit),
  .latch_open (latch_open),
  .blank      (blank),
  .casc_bit   (casc_bit),
  .col_out    (col_out),
  .stages     (stages)
);

// File: tb/col_shift_driver_test.sv
module col_shift_driver_test;

  localparam int N = 32;
  localparam int W = 2 * N;
  // Vector: {valid, bit, latch_open, blank, casc_ready}
  localparam int NV = 24;
  localparam logic [4:0] VEC [NV] = '{
    5'b11101, 5'b10101, 5'b11101, 5'b11101, 5'b10101, 5'b11101,
    5'b11001, 5'b11001, 5'b10001, 5'b00001, 5'b00101, 5'b11111,
    5'b10111, 5'b00011, 5'b01001, 5'b11100, 5'b11100, 5'b00101,
    5'b11001, 5'b11011, 5'b00001, 5'b10110, 5'b00101, 5'b11101
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, v, d, le, bl, cr;
  logic         a_ready, a_cvalid, a_cbit;
  logic         b_ready, b_cvalid, b_cbit;
  logic [N-1:0] a_col, b_col;

  col_shift_driver #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_ready(a_ready), .in_bit(d),
    .latch_open(le), .blank(bl), .casc_valid(a_cvalid), .casc_ready(b_ready),
    .casc_bit(a_cbit), .col_out(a_col));

  col_shift_driver #(.N(N)) uut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(a_cvalid), .in_ready(b_ready),
    .in_bit(a_cbit), .latch_open(le), .blank(bl), .casc_valid(b_cvalid),
    .casc_ready(cr), .casc_bit(b_cbit), .col_out(b_col));

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_sr, m_lat;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] exp_pins;
    exp_pins = bl ? '0 : (le ? m_sr : m_lat);
    chk({b_col, a_col} == exp_pins, req, {b_col, a_col}, exp_pins);
    // R7 / R9: chain tail on the downstream cascade port
    chk(b_cbit == m_sr[W-1], "R7", W'(b_cbit), W'(m_sr[W-1]));
    // R8: pass-through handshake
    chk(a_ready == cr && b_cvalid == v, "R8", W'({a_ready, b_cvalid}), W'({cr, v}));
  endtask

  task automatic step(input logic [4:0] s, input string req);
    @(negedge clk);
    {v, d, le, bl, cr} = s;
    #1 check_all(req);
    @(posedge clk);
    if (v && cr) m_sr = {m_sr[W-2:0], d};   // R2 / R9 model
    if (le) m_lat = m_sr;
    #2 check_all(req);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; {v, d, le, bl, cr} = 5'b00101;
    m_sr = '0; m_lat = '0;
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    #1 check_all("R1");

    // Table walk: R2, R3, R4, R5, R6, R8
    for (int i = 0; i < NV; i++) step(VEC[i], "R4");

    // Pseudo-random stream through the 2N chain (R9)
    lf = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step({1'b1, lf[0], lf[3] | lf[5], lf[7] & lf[9], ~(lf[2] & lf[4])}, "R9");
    end

    // R5: freeze a pattern, then reload the whole chain behind it
    step(5'b11101, "R5");
    for (int i = 0; i < W; i++) step({1'b1, i[1], 3'b001}, "R5");

    // R6: blanking then unblanking shows the same held pattern
    step(5'b00011, "R6");
    step(5'b00011, "R6");
    step(5'b00001, "R6");

    // R3: stalled chain with valid high does not move
    for (int i = 0; i < 4; i++) step(5'b11100, "R3");

    // R4: open again, shift visible in the following cycle
    step(5'b11101, "R4");
    step(5'b10101, "R4");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    {v, d, le, bl, cr} = 5'b00101;
    rst_n = 1'b0;
    m_sr = '0; m_lat = '0;
    #1 check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    #1 check_all("R1");
    step(5'b00001, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule